// File: doc/BRIEF.md
# Four-Phase Bit Line Codec

This block carries single bits over one wire in a bit-synchronous fashion. Every bit occupies a fixed slot split into four back-to-back phases. A preparation phase holds the line at logical 1. A synchronous phase pulls it to logical 0. A data phase shows the bit value. A halt phase returns the line to logical 1. The transmitter accepts one bit at a time through a valid/ready handshake, drives the slot onto `lineOut` and becomes ready again only after the halt phase has finished. While nothing is being sent, the line rests at logical 1.

The receiver watches `lineIn` through a short synchronizer. It treats each logical 1-to-0 fall as the start of a new bit, so it realigns on every bit and keeps no free-running bit clock. It samples the value at the middle of the data phase, counting from the fall. At the end of the halt window it emits either a one-cycle valid strobe with the bit or a one-cycle error strobe. A single polarity input inverts every level on both sides. Phase lengths are parameters in clock cycles: preparation 8, synchronous 16, data 16 and halt 4 by default.

Top module: `quad_phase_codec`

## Requirements
- R1: After reset `txReady` is 1, `rxValid` and `rxError` are 0, and an idle transmitter holds the line at logical 1. Logical 1 is `lineOut` = 1 with `activeLow` = 0 and `lineOut` = 0 with `activeLow` = 1.
- R2: A bit is accepted on a clock edge where `txValid` and `txReady` are both 1. For the next 44 cycles the line is at logical 1 for 8 cycles, logical 0 for 16 cycles, the accepted bit value for 16 cycles, and logical 1 for 4 cycles.
- R3: `txReady` is 0 for all 44 cycles of a bit and returns to 1 in the cycle right after the halt phase.
- R4: Changes on `txValid` and `txBit` while a bit is in progress have no effect on the line waveform of that bit.
- R5: With `activeLow` = 1, every transmitted level is inverted, and `lineIn` is read inverted (physical low means logical 1).
- R6: After a logical 1-to-0 fall on `lineIn` that forms a correct bit, `rxValid` pulses for exactly one cycle. The pulse comes 38 cycles after the fall (2 synchronizer stages + 16 + 16 + 4). `rxBit` holds the level sampled at the data-phase midpoint, 24 cycles after the fall.
- R7: If the line returns to logical 1 fewer than 8 cycles after the fall, `rxError` pulses once, 3 cycles after that return, with no `rxValid`. The receiver then waits for the next fall.
- R8: A logical 0 in any cycle of the 4-cycle halt window gives a single `rxError` pulse instead of `rxValid`, at the time `rxValid` would have been due. `rxValid` and `rxError` are never 1 together.
- R9: The receiver re-synchronises on every bit. Bits sent by the transmitter with any idle gap between them, looped back to `lineIn`, are all decoded in order with no error.
- R10: A synchronous phase of 8 to 15 cycles, followed by a high data phase that keeps the bit slot at 32 cycles, decodes normally as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| activeLow | input | 1 | 1 selects inverted line levels on both sides |
| txValid | input | 1 | Transmit bit offered |
| txBit | input | 1 | Transmit bit value |
| txReady | output | 1 | Transmitter can accept a bit |
| lineOut | output | 1 | Driven line level |
| lineIn | input | 1 | Observed line level |
| rxValid | output | 1 | One-cycle strobe: received bit is good |
| rxBit | output | 1 | Received bit value |
| rxError | output | 1 | One-cycle strobe: received bit was malformed and is dropped |

## Verification
The transmit line is compared on each of the 44 falling clock edges after the accepting edge. `txReady` is expected back on the 45th. On the receive side, the bench drives `lineIn` on falling edges and counts edges from the one that drives the fall. `rxValid` or a halt error is due exactly 38 edges later. A short-sync error is due at the number of low cycles plus 3. Every capture index is compared against these counts, not just against the presence of a strobe.

// File: rtl/qpl_pkg.sv
package qpl_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_PREP,
    TX_SYNC,
    TX_DATA,
    TX_HALT
  } txPhase_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SYNC,
    RX_DATA,
    RX_HALT
  } rxPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     txLoad;
    logic     txAdvance;
    txPhase_e txPhase;
    logic     rxStart;
    logic     rxRun;
    logic     rxSample;
    logic     rxHaltChk;
    logic     rxFinish;
    logic     rxAbort;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic txPhaseEnd;
    logic rxFall;
    logic rxEarlyRise;
    logic rxSyncEnd;
    logic rxMid;
    logic rxDataEnd;
    logic rxHaltEnd;
  } dpFlag_t;

endpackage

// File: rtl/qpl_ctrl.sv
module qpl_ctrl
  import qpl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  dpFlag_t    flags,
  output ctlStrobe_t strobe,
  output logic       txReady
);

  txPhase_e txState, txNext;
  rxPhase_e rxState, rxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      rxState <= RX_IDLE;
    end else begin
      txState <= txNext;
      rxState <= rxNext;
    end
  end

  assign txReady = (txState == TX_IDLE);

  // transmit sequencing
  always_comb begin
    txNext           = txState;
    strobe.txLoad    = 1'b0;
    strobe.txAdvance = 1'b0;
    strobe.txPhase   = txState;
    unique case (txState)
      TX_IDLE: if (txValid) begin
        strobe.txLoad = 1'b1;
        txNext        = TX_PREP;
      end
      TX_PREP: if (flags.txPhaseEnd) begin
        strobe.txAdvance = 1'b1;
        txNext           = TX_SYNC;
      end
      TX_SYNC: if (flags.txPhaseEnd) begin
        strobe.txAdvance = 1'b1;
        txNext           = TX_DATA;
      end
      TX_DATA: if (flags.txPhaseEnd) begin
        strobe.txAdvance = 1'b1;
        txNext           = TX_HALT;
      end
      TX_HALT: if (flags.txPhaseEnd) begin
        strobe.txAdvance = 1'b1;
        txNext           = TX_IDLE;
      end
      default: txNext = TX_IDLE;
    endcase
  end

  // receive sequencing
  always_comb begin
    rxNext           = rxState;
    strobe.rxStart   = 1'b0;
    strobe.rxRun     = 1'b0;
    strobe.rxSample  = 1'b0;
    strobe.rxHaltChk = 1'b0;
    strobe.rxFinish  = 1'b0;
    strobe.rxAbort   = 1'b0;
    unique case (rxState)
      RX_IDLE: if (flags.rxFall) begin
        strobe.rxStart = 1'b1;
        rxNext         = RX_SYNC;
      end
      RX_SYNC: begin
        strobe.rxRun = 1'b1;
        if (flags.rxEarlyRise) begin
          strobe.rxAbort = 1'b1;
          rxNext         = RX_IDLE;
        end else if (flags.rxSyncEnd) begin
          rxNext = RX_DATA;
        end
      end
      RX_DATA: begin
        strobe.rxRun    = 1'b1;
        strobe.rxSample = flags.rxMid;
        if (flags.rxDataEnd) rxNext = RX_HALT;
      end
      RX_HALT: begin
        strobe.rxRun     = 1'b1;
        strobe.rxHaltChk = 1'b1;
        if (flags.rxHaltEnd) begin
          strobe.rxFinish = 1'b1;
          rxNext          = RX_IDLE;
        end
      end
      default: rxNext = RX_IDLE;
    endcase
  end

  // R3: an accepted bit takes the transmitter out of ready
  p_accept_drops_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

endmodule

// File: rtl/qpl_datapath.sv
module qpl_datapath
  import qpl_pkg::*;
#(
  parameter int PREP_LEN    = 8,
  parameter int SYNC_LEN    = 16,
  parameter int DATA_LEN    = 16,
  parameter int HALT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       activeLow,
  input  logic       txBit,
  input  logic       lineIn,
  input  ctlStrobe_t strobe,
  output dpFlag_t    flags,
  output logic       lineOut,
  output logic       rxValid,
  output logic       rxBit,
  output logic       rxError
);

  localparam int MAX_PS     = (PREP_LEN > SYNC_LEN) ? PREP_LEN : SYNC_LEN;
  localparam int MAX_DH     = (DATA_LEN > HALT_LEN) ? DATA_LEN : HALT_LEN;
  localparam int MAX_LEN    = (MAX_PS > MAX_DH) ? MAX_PS : MAX_DH;
  localparam int TX_CNT_W   = $clog2(MAX_LEN + 1);
  localparam int RX_SPAN    = SYNC_LEN + DATA_LEN + HALT_LEN;
  localparam int RX_CNT_W   = $clog2(RX_SPAN + 1);
  localparam int HALF_SYNC  = SYNC_LEN / 2;
  localparam int MID_OFFSET = SYNC_LEN + DATA_LEN / 2;

  // ---------------- transmit path ----------------
  logic [TX_CNT_W-1:0] txCnt;
  logic [TX_CNT_W-1:0] txLast;
  logic                txBitQ;
  logic                txLogical;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt  <= '0;
      txBitQ <= 1'b0;
    end else begin
      if (strobe.txLoad) txBitQ <= txBit;
      if (strobe.txLoad || strobe.txAdvance) txCnt <= '0;
      else if (strobe.txPhase != TX_IDLE)   txCnt <= txCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (strobe.txPhase)
      TX_PREP: txLast = TX_CNT_W'(PREP_LEN - 1);
      TX_SYNC: txLast = TX_CNT_W'(SYNC_LEN - 1);
      TX_DATA: txLast = TX_CNT_W'(DATA_LEN - 1);
      TX_HALT: txLast = TX_CNT_W'(HALT_LEN - 1);
      default: txLast = '0;
    endcase
  end

  always_comb begin
    unique case (strobe.txPhase)
      TX_SYNC: txLogical = 1'b0;
      TX_DATA: txLogical = txBitQ;
      default: txLogical = 1'b1;
    endcase
  end

  assign flags.txPhaseEnd = (txCnt == txLast);
  assign lineOut          = txLogical ^ activeLow;

  // ---------------- receive path ----------------
  logic                   rxIn;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lvl;
  logic                   lvlPrev;
  logic [RX_CNT_W-1:0]    rxCnt;
  logic                   haltBad;

  assign rxIn = lineIn ^ activeLow;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= rxIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
      end
    end
  endgenerate

  assign lvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlPrev <= 1'b1;
      rxCnt   <= '0;
      haltBad <= 1'b0;
      rxBit   <= 1'b0;
      rxValid <= 1'b0;
      rxError <= 1'b0;
    end else begin
      lvlPrev <= lvl;
      if (strobe.rxStart)    rxCnt <= RX_CNT_W'(1);
      else if (strobe.rxRun) rxCnt <= rxCnt + 1'b1;
      else                   rxCnt <= '0;
      if (strobe.rxStart)                haltBad <= 1'b0;
      else if (strobe.rxHaltChk && !lvl) haltBad <= 1'b1;
      if (strobe.rxSample) rxBit <= lvl;
      rxValid <= strobe.rxFinish && !haltBad && lvl;
      rxError <= strobe.rxAbort || (strobe.rxFinish && (haltBad || !lvl));
    end
  end

  assign flags.rxFall      = !lvl && lvlPrev;
  assign flags.rxEarlyRise = lvl && (rxCnt < RX_CNT_W'(HALF_SYNC));
  assign flags.rxSyncEnd   = (rxCnt == RX_CNT_W'(SYNC_LEN - 1));
  assign flags.rxMid       = (rxCnt == RX_CNT_W'(MID_OFFSET));
  assign flags.rxDataEnd   = (rxCnt == RX_CNT_W'(SYNC_LEN + DATA_LEN - 1));
  assign flags.rxHaltEnd   = (rxCnt == RX_CNT_W'(RX_SPAN - 1));

  // R8: good and bad results never coincide
  p_rx_outputs_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, rxError}));

  // R6: a good-bit strobe lasts one cycle
  p_rx_valid_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/quad_phase_codec.sv
module quad_phase_codec
  import qpl_pkg::*;
#(
  parameter int PREP_LEN    = 8,
  parameter int SYNC_LEN    = 16,
  parameter int DATA_LEN    = 16,
  parameter int HALT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic activeLow,
  input  logic txValid,
  input  logic txBit,
  output logic txReady,
  output logic lineOut,
  input  logic lineIn,
  output logic rxValid,
  output logic rxBit,
  output logic rxError
);

  ctlStrobe_t strobe;
  dpFlag_t    flags;

  qpl_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txValid (txValid),
    .flags   (flags),
    .strobe  (strobe),
    .txReady (txReady)
  );

  qpl_datapath #(
    .PREP_LEN    (PREP_LEN),
    .SYNC_LEN    (SYNC_LEN),
    .DATA_LEN    (DATA_LEN),
    .HALT_LEN    (HALT_LEN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .activeLow (activeLow),
    .txBit     (txBit),
    .lineIn    (lineIn),
    .strobe    (strobe),
    .flags     (flags),
    .lineOut   (lineOut),
    .rxValid   (rxValid),
    .rxBit     (rxBit),
    .rxError   (rxError)
  );

  // R1: a ready transmitter rests at logical 1
  p_idle_line_one_r1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> ((lineOut ^ activeLow) == 1'b1));

  // R2: the cycle after acceptance is preparation, logical 1
  p_prep_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> ((lineOut ^ activeLow) == 1'b1));

  // R3: ready returns only after a halt cycle at logical 1
  p_ready_after_halt_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> (($past(lineOut) ^ $past(activeLow)) == 1'b1));

endmodule

// File: tb/tb_quad_phase_codec.sv
`timescale 1ns/1ps
module tb_quad_phase_codec;

  localparam int PREP = 8, SYNC = 16, DATA = 16, HALT = 4, STAGES = 2;
  localparam int BIT_CYC = PREP + SYNC + DATA + HALT;
  localparam int RX_LAT  = STAGES + SYNC + DATA + HALT;

  logic clk = 1'b0, rstN = 1'b0, activeLow = 1'b0;
  logic txValid = 1'b0, txBit = 1'b0, loopOn = 1'b0, drvLine = 1'b1;
  logic txReady, lineOut, lineIn, rxValid, rxBit, rxError;
  int   total = 0, bad = 0;
  bit   done = 1'b0;
  logic expBits [0:63];
  int   wrIdx = 0, rdIdx = 0;

  assign lineIn = loopOn ? lineOut : drvLine;
  always #4 clk = ~clk;

  quad_phase_codec #(
    .PREP_LEN(PREP), .SYNC_LEN(SYNC), .DATA_LEN(DATA), .HALT_LEN(HALT), .SYNC_STAGES(STAGES)
  ) dut (
    .clk(clk), .rstN(rstN), .activeLow(activeLow), .txValid(txValid), .txBit(txBit),
    .txReady(txReady), .lineOut(lineOut), .lineIn(lineIn),
    .rxValid(rxValid), .rxBit(rxBit), .rxError(rxError)
  );

  function automatic logic expLevel(int k, logic b);
    if (k < PREP) return 1'b1;
    if (k < PREP + SYNC) return 1'b0;
    if (k < PREP + SYNC + DATA) return b;
    return 1'b1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // send one bit and compare every line cycle; disturb toggles inputs mid-bit
  task automatic txCheck(logic b, logic pol, logic disturb);
    string tag;
    tag = pol ? "R5 inverted line level" : "R2 line phase level";
    @(negedge clk);
    activeLow = pol; drvLine = ~pol;
    txValid = 1'b1; txBit = b;
    @(negedge clk);
    txValid = disturb; txBit = ~b;   // R4: must not alter this bit
    for (int k = 0; k < BIT_CYC; k++) begin
      if (k > 0) @(negedge clk);
      check(lineOut === (expLevel(k, b) ^ pol), tag, lineOut, expLevel(k, b) ^ pol);
      if (k == PREP + SYNC + 2)
        check(lineOut === (b ^ pol), "R4 data kept despite txBit change", lineOut, b ^ pol);
      check(txReady === 1'b0, "R3 ready low during bit", txReady, 0);
      if (k == BIT_CYC - 3) txValid = 1'b0;
    end
    @(negedge clk);
    check(txReady === 1'b1, "R3 ready after halt", txReady, 1);
  endtask

  // drive one received bit slot; indices counted in falling edges from the first drive
  task automatic rxFrame(int prep, int lowLen, int dataLen, logic b, int haltLen, int glitch,
                         logic pol, output int vIdx, output int eIdx, output int vCnt,
                         output int eCnt, output logic vBit);
    int n;
    logic lv;
    n = prep + lowLen + dataLen + haltLen + 12;
    vIdx = -1; eIdx = -1; vCnt = 0; eCnt = 0; vBit = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rxValid) begin vCnt++; if (vIdx < 0) begin vIdx = i; vBit = rxBit; end end
      if (rxError) begin eCnt++; if (eIdx < 0) eIdx = i; end
      if (i < prep) lv = 1'b1;
      else if (i < prep + lowLen) lv = 1'b0;
      else if (i < prep + lowLen + dataLen) lv = b;
      else if (i < prep + lowLen + dataLen + haltLen) lv = ((i - (prep + lowLen + dataLen)) == glitch) ? 1'b0 : 1'b1;
      else lv = 1'b1;
      activeLow = pol; drvLine = lv ^ pol;
    end
  endtask

  // loopback monitor
  always @(negedge clk) begin
    if (loopOn && rstN) begin
      if (rxValid) begin
        check(rdIdx < wrIdx && rxBit === expBits[rdIdx[5:0]], "R9 loopback bit", rxBit, expBits[rdIdx[5:0]]);
        rdIdx++;
      end
      if (rxError) check(1'b0, "R9 loopback error strobe", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 run hung actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int vI, eI, vC, eC, gap;
    logic vB, rb, rp, rd;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txReady === 1'b1, "R1 reset ready", txReady, 1);
    check(lineOut === 1'b1, "R1 idle line high", lineOut, 1);
    check(rxValid === 1'b0, "R1 reset rxValid", rxValid, 0);
    check(rxError === 1'b0, "R1 reset rxError", rxError, 0);
    activeLow = 1'b1; drvLine = 1'b0;
    @(negedge clk);
    check(lineOut === 1'b0, "R1 R5 idle line inverted", lineOut, 0);
    activeLow = 1'b0; drvLine = 1'b1;

    // directed transmit
    txCheck(1'b1, 1'b0, 1'b0);
    txCheck(1'b0, 1'b0, 1'b1);
    txCheck(1'b1, 1'b1, 1'b1);
    txCheck(1'b0, 1'b1, 1'b0);
    // random transmit
    for (int i = 0; i < 8; i++) begin
      rb = 1'($urandom % 2); rp = 1'($urandom % 2); rd = 1'($urandom % 2);
      txCheck(rb, rp, rd);
    end
    @(negedge clk); activeLow = 1'b0; drvLine = 1'b1;
    repeat (4) @(negedge clk);

    // directed receive
    rxFrame(6, 16, 16, 1'b1, 4, -1, 1'b0, vI, eI, vC, eC, vB);
    check(vC == 1 && eC == 0, "R6 one good strobe", vC, 1);
    check(vI == 6 + RX_LAT, "R6 valid latency", vI, 6 + RX_LAT);
    check(vB === 1'b1, "R6 bit one", vB, 1);

    rxFrame(3, 16, 16, 1'b0, 4, -1, 1'b0, vI, eI, vC, eC, vB);
    check(vC == 1 && eC == 0, "R6 one good strobe bit zero", vC, 1);
    check(vI == 3 + RX_LAT, "R6 valid latency bit zero", vI, 3 + RX_LAT);
    check(vB === 1'b0, "R6 bit zero", vB, 0);

    rxFrame(5, 16, 16, 1'b1, 4, -1, 1'b1, vI, eI, vC, eC, vB);
    check(vC == 1 && vB === 1'b1 && vI == 5 + RX_LAT, "R5 inverted receive", vI, 5 + RX_LAT);
    rxFrame(5, 16, 16, 1'b0, 4, -1, 1'b1, vI, eI, vC, eC, vB);
    check(vC == 1 && vB === 1'b0, "R5 inverted receive zero", vB, 0);

    rxFrame(4, 7, 25, 1'b1, 4, -1, 1'b0, vI, eI, vC, eC, vB);
    check(eC == 1 && vC == 0, "R7 short sync error only", eC, 1);
    check(eI == 4 + 7 + STAGES + 1, "R7 short sync error timing", eI, 4 + 7 + STAGES + 1);
    rxFrame(2, 16, 16, 1'b0, 4, -1, 1'b0, vI, eI, vC, eC, vB);
    check(vC == 1 && eC == 0 && vB === 1'b0, "R7 rearm after error", vC, 1);

    rxFrame(4, 8, 24, 1'b1, 4, -1, 1'b0, vI, eI, vC, eC, vB);
    check(vC == 1 && eC == 0 && vB === 1'b1, "R10 sync at half length", vC, 1);
    rxFrame(4, 10, 22, 1'b1, 4, -1, 1'b0, vI, eI, vC, eC, vB);
    check(vC == 1 && vB === 1'b1 && vI == 4 + RX_LAT, "R10 shortened sync", vI, 4 + RX_LAT);

    rxFrame(4, 16, 16, 1'b1, 4, 0, 1'b0, vI, eI, vC, eC, vB);
    check(eC == 1 && vC == 0, "R8 halt glitch first cycle", eC, 1);
    check(eI == 4 + RX_LAT, "R8 halt error timing", eI, 4 + RX_LAT);
    rxFrame(4, 16, 16, 1'b0, 4, 3, 1'b0, vI, eI, vC, eC, vB);
    check(eC == 1 && vC == 0 && eI == 4 + RX_LAT, "R8 halt glitch last cycle", eI, 4 + RX_LAT);

    // random loopback with varying gaps and polarity
    loopOn = 1'b1;
    for (int i = 0; i < 24; i++) begin
      gap = $urandom % 5;
      rb  = 1'($urandom % 2);
      @(negedge clk);
      while (!txReady) @(negedge clk);
      repeat (gap) @(negedge clk);
      if (i % 6 == 5) activeLow = ~activeLow;
      txValid = 1'b1; txBit = rb;
      expBits[wrIdx[5:0]] = rb; wrIdx++;
      @(negedge clk);
      txValid = 1'b0;
    end
    repeat (60) @(negedge clk);
    check(rdIdx == wrIdx, "R9 loopback count", rdIdx, wrIdx);
    loopOn = 1'b0; activeLow = 1'b0; drvLine = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule